// File: doc/BRIEF.md
# Time-Slotted Shared SRAM Sequencer

This block is the only master of one asynchronous single-port static RAM. Two clients share that RAM: a display fetch path that reads, and a host that writes. Access length is not signalled by the memory. Every access takes a fixed number of clock cycles, which is the sum of a drive phase and a settle phase. Both lengths are parameters, so the sequencer only counts. It never waits for an outside event.

Time is cut into slots of equal length, and the slots alternate. A display slot comes first after reset, then a host slot, and this pattern never changes. The display fetch therefore gets a read at an exact cadence, and host traffic can never delay it. A host write is captured into a one-entry holding register and flagged busy. It goes to the RAM in the next host slot. A host slot with nothing pending leaves the chip deselected.

The display side gets an acknowledge on the cycle its address is sampled. It later gets a one-cycle done pulse, and the read data is held until the next read completes. The host side gets a one-cycle done pulse when its write slot has finished.

Top module: `sram_slot_seq`

## Requirements
- R1: While `rst` is high, `sram_ce_n`, `sram_we_n` and `sram_oe_n` are high, and `sram_dq_oe`, `host_busy`, `vid_done` and `host_done` are low.
- R2: Slots last L = DRIVE_CYC + WAIT_CYC cycles and alternate display/host, with a display slot starting on the first clock edge after reset is released. `vid_addr_ack` is high exactly on the last cycle before each display slot (including the first cycle after reset release), and the `vid_addr` present on that cycle is the address read.
- R3: `vid_done` pulses for one cycle, the cycle after each display slot ends, so exactly every 2L cycles whatever the host does. `vid_rd_data` then holds the `sram_rdata` value seen on the slot's last cycle.
- R4: `sram_oe_n` is low during every display-slot cycle and high otherwise. `sram_dq_oe` is high only during a host slot that carries a write, so the two are never active together.
- R5: A write request (`host_wr_req` high while `host_busy` is low) is captured, and `host_busy` is high from the next cycle. A request made while `host_busy` is high is ignored and changes no memory location.
- R6: A write captured in cycle c is carried out in the first host slot that starts at cycle c+2 or later. `sram_addr` and `sram_wdata` hold the captured values for the whole slot, and the memory word then holds the new data. `host_busy` falls as that slot begins.
- R7: In a write slot, `sram_we_n` is low on slot cycles 1 to L-2 only. The address has been stable for at least one cycle before it falls, and the data is still driven on the cycle it rises.
- R8: `host_done` pulses for one cycle, on the cycle after a write slot's last cycle.
- R9: `sram_ce_n` is low in every display slot and in every write slot, and high in host slots that carry no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vid_addr | input | ADDR_W | Display fetch address |
| vid_addr_ack | output | 1 | Display address sampled at the end of this cycle |
| vid_rd_data | output | DATA_W | Last word read for the display path |
| vid_done | output | 1 | One-cycle pulse: display read complete |
| host_wr_req | input | 1 | Host write request, taken when not busy |
| host_wr_addr | input | ADDR_W | Host write address |
| host_wr_data | input | DATA_W | Host write data |
| host_busy | output | 1 | Holding register full; requests ignored |
| host_done | output | 1 | One-cycle pulse: host write complete |
| sram_addr | output | ADDR_W | RAM address |
| sram_wdata | output | DATA_W | RAM write data |
| sram_dq_oe | output | 1 | Enable for the write data onto the RAM data bus |
| sram_rdata | input | DATA_W | RAM read data |
| sram_ce_n | output | 1 | RAM chip enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |

## Verification
The properties assume a synchronous reset held for at least one clock edge. They also assume that the host may raise a request on any cycle, busy or not. The cadence property relies only on the slot counter, so it holds whatever the host inputs do.

The stimulus posts one write at each of the 2L phases of the slot pattern. It raises an extra request on the first busy cycle, which must be ignored. It walks the display address across the whole space, so that every written word and every word touched by an ignored request is read back through the display path.

// File: rtl/sram_slot_seq_pkg.sv
package sram_slot_seq_pkg;
    typedef enum logic {SLOT_VIDEO = 1'b0, SLOT_HOST = 1'b1} slot_kind_e;

    function automatic int slot_cycles(input int drive_cyc, input int settle_cyc);
        return drive_cyc + settle_cyc;
    endfunction
endpackage

// File: rtl/sram_slot_timer.sv
module sram_slot_timer
    import sram_slot_seq_pkg::*;
#(
    parameter int SLOT_LEN = 3,
    localparam int CNT_W   = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_o,
    output logic             host_slot_o,
    output logic             slot_last_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_LEN - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        slot_kind_e       kind;
    } timer_t;

    timer_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt  = '0;
            st_d.kind = (st_q.kind == SLOT_HOST) ? SLOT_VIDEO : SLOT_HOST;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    // Reset parks the timer on the last cycle of an empty host slot,
    // so the first display slot opens on the first edge after reset.
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt  <= LAST;
            st_q.kind <= SLOT_HOST;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o       = st_q.cnt;
    assign host_slot_o = (st_q.kind == SLOT_HOST);
    assign slot_last_o = (st_q.cnt == LAST);
endmodule

// File: rtl/sram_wr_hold.sv
module sram_wr_hold #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              take_i,
    output logic              full_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);
    typedef struct packed {
        logic              full;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (take_i) begin
            h_d.full = 1'b0;
        end else if (req_i && !h_q.full) begin
            h_d.full = 1'b1;
            h_d.addr = addr_i;
            h_d.data = data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign full_o = h_q.full;
    assign addr_o = h_q.addr;
    assign data_o = h_q.data;
endmodule

// File: rtl/sram_slot_seq.sv
module sram_slot_seq
    import sram_slot_seq_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int DRIVE_CYC = 2,
    parameter int WAIT_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] vid_addr,
    output logic              vid_addr_ack,
    output logic [DATA_W-1:0] vid_rd_data,
    output logic              vid_done,
    input  logic              host_wr_req,
    input  logic [ADDR_W-1:0] host_wr_addr,
    input  logic [DATA_W-1:0] host_wr_data,
    output logic              host_busy,
    output logic              host_done,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_wdata,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_rdata,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n
);
    localparam int SLOT_LEN = slot_cycles(DRIVE_CYC, WAIT_CYC);
    localparam int CNT_W    = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_LEN - 1);

    logic [CNT_W-1:0]  cnt;
    logic              host_slot;
    logic              slot_last;
    logic              hold_full;
    logic [ADDR_W-1:0] hold_addr;
    logic [DATA_W-1:0] hold_data;
    logic              take;

    sram_slot_timer #(.SLOT_LEN(SLOT_LEN)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .cnt_o       (cnt),
        .host_slot_o (host_slot),
        .slot_last_o (slot_last)
    );

    sram_wr_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .req_i  (host_wr_req),
        .addr_i (host_wr_addr),
        .data_i (host_wr_data),
        .take_i (take),
        .full_o (hold_full),
        .addr_o (hold_addr),
        .data_o (hold_data)
    );

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              wr_act;
        logic [DATA_W-1:0] rd_data;
        logic              vid_done;
        logic              host_done;
    } path_t;

    path_t p_d, p_q;

    // The pending write moves to the RAM on the edge that opens a host slot.
    assign take = slot_last && !host_slot && hold_full;

    always_comb begin
        p_d           = p_q;
        p_d.vid_done  = 1'b0;
        p_d.host_done = 1'b0;
        if (slot_last) begin
            p_d.wr_act = take;
            if (host_slot) begin
                p_d.addr      = vid_addr;
                p_d.host_done = p_q.wr_act;
            end else begin
                p_d.rd_data  = sram_rdata;
                p_d.vid_done = 1'b1;
                if (take) begin
                    p_d.addr  = hold_addr;
                    p_d.wdata = hold_data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign vid_addr_ack = slot_last && host_slot;
    assign vid_rd_data  = p_q.rd_data;
    assign vid_done     = p_q.vid_done;
    assign host_busy    = hold_full;
    assign host_done    = p_q.host_done;
    assign sram_addr    = p_q.addr;
    assign sram_wdata   = p_q.wdata;
    assign sram_dq_oe   = p_q.wr_act;
    assign sram_ce_n    = !(p_q.wr_act || !host_slot);
    assign sram_oe_n    = host_slot;
    assign sram_we_n    = !(p_q.wr_act && (cnt != '0) && (cnt != LAST));
endmodule

// File: rtl/sram_slot_seq_chk.sv
module sram_slot_seq_chk #(
    parameter int ADDR_W   = 8,
    parameter int SLOT_LEN = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              sram_ce_n,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic              sram_dq_oe,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              vid_done,
    input logic              host_done,
    input logic              host_wr_req,
    input logic              host_busy
);
    logic [15:0] gap_q;
    logic        seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (vid_done) begin
            gap_q  <= 16'd1;
            seen_q <= 1'b1;
        end else begin
            gap_q <= gap_q + 16'd1;
        end
    end

    AST_OE_DQ_EXCL: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n |-> !sram_dq_oe); // R4
    AST_WE_ADDR_SETTLED: assert property (@(posedge clk) disable iff (rst)
        $fell(sram_we_n) |-> $stable(sram_addr)); // R7
    AST_WE_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> sram_dq_oe); // R7
    AST_VID_CADENCE: assert property (@(posedge clk) disable iff (rst)
        (vid_done && seen_q) |-> (gap_q == 16'(2 * SLOT_LEN))); // R3
    AST_HOST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        host_done |=> !host_done); // R8
    AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (host_wr_req && !host_busy) |=> host_busy); // R5
    AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> !sram_ce_n); // R9
    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(vid_done && host_done)); // R8
endmodule

bind sram_slot_seq sram_slot_seq_chk #(
    .ADDR_W   (ADDR_W),
    .SLOT_LEN (DRIVE_CYC + WAIT_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sram_ce_n   (sram_ce_n),
    .sram_we_n   (sram_we_n),
    .sram_oe_n   (sram_oe_n),
    .sram_dq_oe  (sram_dq_oe),
    .sram_addr   (sram_addr),
    .vid_done    (vid_done),
    .host_done   (host_done),
    .host_wr_req (host_wr_req),
    .host_busy   (host_busy)
);

// File: tb/sram_slot_seq_bench.sv
module sram_slot_seq_bench;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int NC = 2;
    localparam int KC = 1;
    localparam int L  = NC + KC;
    localparam int P  = 2 * L;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] vid_addr = '0;
    logic          vid_addr_ack;
    logic [DW-1:0] vid_rd_data;
    logic          vid_done;
    logic          host_wr_req = 1'b0;
    logic [AW-1:0] host_wr_addr = '0;
    logic [DW-1:0] host_wr_data = '0;
    logic          host_busy;
    logic          host_done;
    logic [AW-1:0] sram_addr;
    logic [DW-1:0] sram_wdata;
    logic          sram_dq_oe;
    logic [DW-1:0] sram_rdata;
    logic          sram_ce_n;
    logic          sram_we_n;
    logic          sram_oe_n;

    always #5 clk = ~clk;

    sram_slot_seq #(.ADDR_W(AW), .DATA_W(DW), .DRIVE_CYC(NC), .WAIT_CYC(KC)) u_sram_slot_seq (
        .clk(clk), .rst(rst),
        .vid_addr(vid_addr), .vid_addr_ack(vid_addr_ack),
        .vid_rd_data(vid_rd_data), .vid_done(vid_done),
        .host_wr_req(host_wr_req), .host_wr_addr(host_wr_addr),
        .host_wr_data(host_wr_data), .host_busy(host_busy), .host_done(host_done),
        .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_dq_oe(sram_dq_oe),
        .sram_rdata(sram_rdata), .sram_ce_n(sram_ce_n),
        .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n)
    );

    // RAM model: initial pattern on reset, write on the clock while strobed.
    logic [DW-1:0] mem [256];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= DW'(i) ^ 8'hA5;
        end else if (!sram_ce_n && !sram_we_n && sram_dq_oe) begin
            mem[sram_addr] <= sram_wdata;
        end
    end
    assign sram_rdata = (!sram_ce_n && !sram_oe_n) ? mem[sram_addr] : '0;

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    logic [DW-1:0] shadow [256];
    int            cyc;
    int            wr_ca;
    int            wr_s;
    logic [AW-1:0] wr_a;
    logic [DW-1:0] wr_d;
    int            n_posted;
    int            rd_idx;
    logic [AW-1:0] rd_exp_a;

    initial begin
        for (int i = 0; i < 256; i++) shadow[i] = DW'(i) ^ 8'hA5;
        wr_ca = -1; wr_s = -1; n_posted = 0; rd_idx = 0; rd_exp_a = '0;
        wr_a = '0; wr_d = '0;
        repeat (3) begin
            @(negedge clk);
            check("R1 ce_n", 32'(sram_ce_n), 32'd1);
            check("R1 we_n", 32'(sram_we_n), 32'd1);
            check("R1 oe_n", 32'(sram_oe_n), 32'd1);
            check("R1 dq_oe", 32'(sram_dq_oe), 32'd0);
            check("R1 busy", 32'(host_busy), 32'd0);
            check("R1 dones", 32'({vid_done, host_done}), 32'd0);
        end
        rst = 1'b0;
        cyc = -1;
        check("R2 ack first", 32'(vid_addr_ack), 32'd1);
        rd_exp_a = vid_addr;
        rd_idx = 1;
        while (!(n_posted == P && wr_s < 0 && rd_idx >= 300)) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            begin
                int  pos;
                int  cnt;
                bit  vslot;
                bit  in_wr;
                bit  e_ack;
                pos   = cyc % P;
                cnt   = cyc % L;
                vslot = (pos < L);
                in_wr = (wr_s >= 0) && (cyc >= wr_s) && (cyc < wr_s + L);
                e_ack = ((cyc + 1) % P) == 0;
                check("R2 ack", 32'(vid_addr_ack), 32'(e_ack));
                check("R4 oe_n", 32'(sram_oe_n), 32'(!vslot));
                check("R4 dq_oe", 32'(sram_dq_oe), 32'(in_wr));
                check("R9 ce_n", 32'(sram_ce_n), 32'(!(vslot || in_wr)));
                check("R7 we_n", 32'(sram_we_n), 32'(!(in_wr && cnt >= 1 && cnt <= L - 2)));
                check("R3 vid_done", 32'(vid_done), 32'(pos == L));
                if (pos == L) check("R3 rd data", 32'(vid_rd_data), 32'(shadow[rd_exp_a]));
                if (vslot) check("R2 read addr", 32'(sram_addr), 32'(rd_exp_a));
                if (in_wr) begin
                    check("R6 wr addr", 32'(sram_addr), 32'(wr_a));
                    check("R6 wr data", 32'(sram_wdata), 32'(wr_d));
                end
                check("R5 busy", 32'(host_busy),
                      32'((wr_ca >= 0) && (cyc >= wr_ca + 1) && (cyc < wr_s)));
                check("R8 host_done", 32'(host_done), 32'((wr_s >= 0) && (cyc == wr_s + L)));
                if (wr_s >= 0 && cyc == wr_s + L) begin
                    shadow[wr_a] = wr_d;
                    wr_s = -1;
                    wr_ca = -1;
                end
                // display address: hold it on the acknowledge cycle, advance afterwards
                if (e_ack) begin
                    rd_exp_a = vid_addr;
                    rd_idx++;
                end else begin
                    vid_addr = AW'(rd_idx);
                end
                // host stimulus: one write per slot phase, plus one ignored request
                host_wr_req = 1'b0;
                if (wr_s < 0 && n_posted < P && pos == n_posted) begin
                    int s;
                    s = cyc + 2;
                    while ((s % P) != L) s++;
                    wr_a = AW'(8'hC0 + n_posted);
                    wr_d = DW'(8'h30 + 17 * n_posted);
                    host_wr_req  = 1'b1;
                    host_wr_addr = wr_a;
                    host_wr_data = wr_d;
                    wr_ca = cyc;
                    wr_s  = s;
                    n_posted++;
                end else if (wr_ca >= 0 && cyc == wr_ca + 1) begin
                    host_wr_req  = 1'b1;
                    host_wr_addr = AW'(8'h10 + n_posted);
                    host_wr_data = 8'hEE;
                end
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule